// File: doc/BRIEF.md
# I2C-Controlled Eight-Pin GPIO Expander

This block is an I2C target that gives a bus master eight general-purpose pins. Four byte-wide registers sit behind the bus: a sampled input register, an output-level register, a polarity mask and a direction register. The master first writes a command byte that picks one of the four registers. It then writes data bytes into that register, or it issues a repeated START with the read bit set and reads the register back. Each pin either drives its output-register bit or stays high-impedance, depending on its direction bit.

The bus lines are sampled by a system clock that runs much faster than SCL. The target pulls SDA low through an open-drain style `sda_drive_low` output. An active-low interrupt output signals that an input-configured pin no longer matches the captured input value. Reading the input register re-captures the pins and clears the interrupt. Two strap pins set the low bits of the target address, so four of these blocks can share one bus. A synchronous active-high system reset and an active-low reset pin have the same effect.

Top module: `gpio_expander`

## Requirements
- R1: After `rst` high, all registers return to their defaults: output register 0xFF, direction register 0xFF (every pin an input, `pin_oe` all 0), polarity mask 0x00. After reset, `irq_n` is 1 and `sda_drive_low` is 0.
- R2: The 7-bit target address is {5'b11100, addr_sel[1], addr_sel[0]}, with R/W as the eighth bit. On a matching address the target holds SDA low for the ninth clock (ACK). On any other address it leaves SDA released, and the data clocked after it changes nothing.
- R3: Command values 0 (input), 1 (output), 2 (polarity) and 3 (direction) are acknowledged. A command of 4 or more is not acknowledged, and no register changes.
- R4: A data byte written after a command goes into the selected register. `pin_out` equals the output register. Bit i of `pin_oe` is the inverse of direction bit i, where 0 means the pin is driven and 1 means it is an input. These pins change only after a write or a reset.
- R5: A read transfer returns the selected register MSB first. Each further byte that the master acknowledges returns the same register again.
- R6: Reading register 0 returns the synchronised pin levels XOR the polarity mask.
- R7: `irq_n` goes low when an input-configured pin differs from the captured input register. It goes low on the third rising clock after the pin change (two synchroniser stages plus one register). Differences on output-configured pins are ignored.
- R8: A read of register 0 captures the pins into the input register, which releases `irq_n`. `irq_n` also releases when the pins return to the captured value.
- R9: Driving `rst_pin_n` low has the same effect as `rst`, including abandoning a transfer in progress.
- R10: A write to register 0 is acknowledged but has no effect. The captured input value and `irq_n` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| rst_pin_n | input | 1 | Active-low reset pin, same effect as rst |
| addr_sel | input | 2 | Strap pins forming the two low address bits |
| scl_in | input | 1 | I2C clock line level |
| sda_in | input | 1 | I2C data line level |
| sda_drive_low | output | 1 | 1 pulls SDA low (open-drain) |
| pin_in | input | 8 | Pin levels seen at the pads |
| pin_out | output | 8 | Level for pins configured as outputs |
| pin_oe | output | 8 | 1 enables the pad driver for that pin |
| irq_n | output | 1 | Active-low interrupt, open-drain level |

## Verification
Bus-side results depend on SCL edges, which reach the state machine three clocks late (two synchroniser flops plus an edge-detect flop). The bench therefore holds each SCL phase for eight clocks and samples ACK and read bits in the middle of SCL high. Register writes reach `pin_out`/`pin_oe` within a few clocks of the ACK falling edge, so those pins are checked after the STOP. The interrupt is due on the third rising edge after a pin change. The bench checks that `irq_n` is still high after two falling edges and low after the third. After a capture, the release is checked a few clocks after the STOP.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_MACK
  } tgt_state_e;

  // Register selection codes carried by the command byte
  localparam logic [1:0] SEL_IN  = 2'd0;
  localparam logic [1:0] SEL_OUT = 2'd1;
  localparam logic [1:0] SEL_POL = 2'd2;
  localparam logic [1:0] SEL_DIR = 2'd3;

  typedef struct packed {
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;

endpackage

// File: rtl/gpx_bus_sync.sv
module gpx_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  output gpx_pkg::bus_ev_t ev
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] now;
  logic [NLINES-1:0] prv;

  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              last;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '1;
        last  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], raw[g]};
        last  <= chain[STAGES-1];
      end
    end
    assign now[g] = chain[STAGES-1];
    assign prv[g] = last;
  end

  // bit 1 = SCL, bit 0 = SDA
  assign ev.sda      = now[0];
  assign ev.scl_rise = now[1] & ~prv[1];
  assign ev.scl_fall = ~now[1] & prv[1];
  assign ev.start    = now[1] & prv[1] & prv[0] & ~now[0];
  assign ev.stop     = now[1] & prv[1] & ~prv[0] & now[0];
endmodule

// File: rtl/gpx_i2c_target.sv
module gpx_i2c_target #(
  parameter int         DW      = 8,
  parameter int         NREGS   = 4,
  parameter logic [4:0] ADDR_HI = 5'b11100,
  localparam int        SELW    = $clog2(NREGS),
  localparam int        CNTW    = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst,
  input  gpx_pkg::bus_ev_t ev,
  input  logic [1:0]       addr_lo,
  input  logic [DW-1:0]    rd_data,
  output logic             sda_low,
  output logic             wr_en,
  output logic [SELW-1:0]  wr_sel,
  output logic [DW-1:0]    wr_data,
  output logic             rd_load,
  output logic [SELW-1:0]  rd_sel
);
  import gpx_pkg::*;

  tgt_state_e      state;
  logic [CNTW-1:0] cnt;
  logic [DW-1:0]   shreg;
  logic            got;
  logic            rw;
  logic [SELW-1:0] ptr;

  assign wr_sel = ptr;
  assign rd_sel = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      got     <= 1'b0;
      rw      <= 1'b0;
      ptr     <= '0;
      sda_low <= 1'b0;
      wr_en   <= 1'b0;
      wr_data <= '0;
      rd_load <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      rd_load <= 1'b0;
      if (ev.start) begin
        state   <= ST_ADDR;
        cnt     <= '0;
        got     <= 1'b0;
        sda_low <= 1'b0;
      end else if (ev.stop) begin
        state   <= ST_IDLE;
        got     <= 1'b0;
        sda_low <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (ev.scl_rise) begin
              shreg <= {shreg[DW-2:0], ev.sda};
              cnt   <= cnt + 1'b1;
              if (cnt == CNTW'(DW - 1)) got <= 1'b1;
            end else if (ev.scl_fall && got) begin
              got <= 1'b0;
              if (state == ST_ADDR) begin
                if (shreg[DW-1:1] == {ADDR_HI, addr_lo}) begin
                  rw      <= shreg[0];
                  sda_low <= 1'b1;
                  state   <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_CMD) begin
                if (shreg < DW'(NREGS)) begin
                  ptr     <= shreg[SELW-1:0];
                  sda_low <= 1'b1;
                  state   <= ST_CMD_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                wr_en   <= 1'b1;
                wr_data <= shreg;
                sda_low <= 1'b1;
                state   <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: begin
            if (ev.scl_fall) begin
              sda_low <= 1'b0;
              cnt     <= '0;
              if (state == ST_ADDR_ACK && rw) begin
                rd_load <= 1'b1;
                state   <= ST_TX;
              end else if (state == ST_ADDR_ACK) begin
                state <= ST_CMD;
              end else begin
                state <= ST_WDATA;
              end
            end
          end
          ST_TX: begin
            if (rd_load) begin
              shreg   <= rd_data;
              sda_low <= ~rd_data[DW-1];
              cnt     <= '0;
            end else if (ev.scl_fall) begin
              if (cnt == CNTW'(DW - 1)) begin
                sda_low <= 1'b0;
                state   <= ST_MACK;
              end else begin
                shreg   <= {shreg[DW-2:0], 1'b0};
                sda_low <= ~shreg[DW-2];
                cnt     <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (ev.scl_rise) begin
              got <= ~ev.sda;
            end else if (ev.scl_fall) begin
              got <= 1'b0;
              if (got) begin
                rd_load <= 1'b1;
                state   <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile #(
  parameter int            DW      = 8,
  parameter int            NREGS   = 4,
  parameter int            PSYNC   = 2,
  parameter logic [DW-1:0] OUT_RST = '1,
  parameter logic [DW-1:0] DIR_RST = '1,
  parameter logic [DW-1:0] POL_RST = '0,
  localparam int           SELW    = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   pin_in,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_load,
  input  logic [SELW-1:0] rd_sel,
  output logic [DW-1:0]   rd_data,
  output logic [DW-1:0]   out_q,
  output logic [DW-1:0]   dir_q,
  output logic [DW-1:0]   pin_s,
  output logic            irq_n
);
  import gpx_pkg::*;

  logic [DW-1:0] psync [PSYNC];
  logic [DW-1:0] pol_q;
  logic [DW-1:0] in_q;

  always_ff @(posedge clk) begin
    psync[0] <= pin_in;
    for (int i = 1; i < PSYNC; i++) psync[i] <= psync[i-1];
  end
  assign pin_s = psync[PSYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= OUT_RST;
      dir_q <= DIR_RST;
      pol_q <= POL_RST;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_OUT: out_q <= wr_data;
        SEL_POL: pol_q <= wr_data;
        SEL_DIR: dir_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q <= pin_s;
    end else if (rd_load && rd_sel == SEL_IN) begin
      in_q <= pin_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~|((pin_s ^ in_q) & dir_q);
  end

  always_comb begin
    case (rd_sel)
      SEL_IN:  rd_data = pin_s ^ pol_q;
      SEL_OUT: rd_data = out_q;
      SEL_POL: rd_data = pol_q;
      default: rd_data = dir_q;
    endcase
  end
endmodule

// File: rtl/gpio_expander.sv
module gpio_expander #(
  parameter int         DW          = 8,
  parameter int         NREGS       = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_HI     = 5'b11100,
  localparam int        SELW        = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rst_pin_n,
  input  logic [1:0]    addr_sel,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_drive_low,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_oe,
  output logic          irq_n
);
  import gpx_pkg::*;

  logic            rst_i;
  bus_ev_t         ev;
  logic            wr_en;
  logic [SELW-1:0] wr_sel;
  logic [DW-1:0]   wr_data;
  logic            rd_load;
  logic [SELW-1:0] rd_sel;
  logic [DW-1:0]   rd_data;
  logic [DW-1:0]   out_q;
  logic [DW-1:0]   dir_q;
  logic [DW-1:0]   pin_s;

  assign rst_i = rst | ~rst_pin_n;

  gpx_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst_i),
    .scl_in (scl_in),
    .sda_in (sda_in),
    .ev     (ev)
  );

  gpx_i2c_target #(.DW(DW), .NREGS(NREGS), .ADDR_HI(ADDR_HI)) u_tgt (
    .clk     (clk),
    .rst     (rst_i),
    .ev      (ev),
    .addr_lo (addr_sel),
    .rd_data (rd_data),
    .sda_low (sda_drive_low),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_load (rd_load),
    .rd_sel  (rd_sel)
  );

  gpx_regfile #(.DW(DW), .NREGS(NREGS), .PSYNC(SYNC_STAGES)) u_regs (
    .clk     (clk),
    .rst     (rst_i),
    .pin_in  (pin_in),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_load (rd_load),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .out_q   (out_q),
    .dir_q   (dir_q),
    .pin_s   (pin_s),
    .irq_n   (irq_n)
  );

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker #(
  parameter int DW   = 8,
  parameter int SELW = 2
) (
  input logic            clk,
  input logic            rst_i,
  input logic            scl_in,
  input logic            sda_drive_low,
  input logic [DW-1:0]   pin_out,
  input logic [DW-1:0]   pin_oe,
  input logic            irq_n,
  input logic            wr_en,
  input logic            rd_load,
  input logic [SELW-1:0] rd_sel,
  input logic [DW-1:0]   pin_s
);
  logic rst_seen_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_seen_q <= rst_i;
    if (rst_seen_q) begin
      AST_RESET_DEFAULTS: assert (pin_oe == '0 && pin_out == '1 && irq_n && !sda_drive_low); // R1
    end
  end

  AST_SDA_CHANGES_SCL_LOW: assert property (@(posedge clk) disable iff (rst_i)
    $rose(sda_drive_low) |-> !scl_in); // R2

  AST_PINS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst_i)
    (!$stable(pin_out) || !$stable(pin_oe)) |-> ($past(wr_en) || $past(rst_i))); // R4

  AST_IRQ_NEEDS_INPUT_PIN: assert property (@(posedge clk) disable iff (rst_i)
    !irq_n |-> ($past(pin_oe) != '1)); // R7

  AST_CAPTURE_RELEASES_IRQ: assert property (@(posedge clk) disable iff (rst_i)
    (rd_load && rd_sel == '0) ##1 $stable(pin_s) |=> irq_n); // R8
endmodule

bind gpio_expander gpx_checker #(.DW(DW), .SELW(SELW)) u_chk (
  .clk           (clk),
  .rst_i         (rst_i),
  .scl_in        (scl_in),
  .sda_drive_low (sda_drive_low),
  .pin_out       (pin_out),
  .pin_oe        (pin_oe),
  .irq_n         (irq_n),
  .wr_en         (wr_en),
  .rd_load       (rd_load),
  .rd_sel        (rd_sel),
  .pin_s         (pin_s)
);

// File: tb/gpio_expander_bench.sv
module gpio_expander_bench;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rst_pin_n = 1'b1;
  logic [1:0] addr_sel = 2'b10;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_bus;
  logic       sda_drive_low;
  logic [7:0] pin_in = 8'hA5;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;
  logic       irq_n;

  int vectors = 0;
  int miscompares = 0;

  logic [7:0] exp_q [$];
  logic [7:0] act_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_drive_low;

  gpio_expander u_gpio_expander (
    .clk           (clk),
    .rst           (rst),
    .rst_pin_n     (rst_pin_n),
    .addr_sel      (addr_sel),
    .scl_in        (scl_m),
    .sda_in        (sda_bus),
    .sda_drive_low (sda_drive_low),
    .pin_in        (pin_in),
    .pin_out       (pin_out),
    .pin_oe        (pin_oe),
    .irq_n         (irq_n)
  );

  localparam logic [6:0] DEV = {5'b11100, 2'b10};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pairs read bytes with expected bytes
  always @(negedge clk) begin
    if (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] a;
      logic [7:0] e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {24'd0, a}, {24'd0, e});
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack = ~sda_bus; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      b = {b[6:0], sda_bus}; wq();
      scl_m = 1'b0; wq();
    end
    sda_m = ~mack; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic reg_write(input logic [7:0] sel, input logic [7:0] data, input string req);
    logic ack;
    i2c_start();
    wr_byte({DEV, 1'b0}, ack); chk({req, " R2 address ack"}, {31'd0, ack}, 32'd1);
    wr_byte(sel, ack);         chk({req, " R3 command ack"}, {31'd0, ack}, 32'd1);
    wr_byte(data, ack);        chk({req, " data ack"}, {31'd0, ack}, 32'd1);
    i2c_stop();
    repeat (4) @(negedge clk);
  endtask

  task automatic reg_read(input logic [7:0] sel, input logic [7:0] exp, input int n, input string req);
    logic ack;
    logic [7:0] b;
    i2c_start();
    wr_byte({DEV, 1'b0}, ack); chk({req, " R2 address ack"}, {31'd0, ack}, 32'd1);
    wr_byte(sel, ack);         chk({req, " R3 command ack"}, {31'd0, ack}, 32'd1);
    i2c_start();
    wr_byte({DEV, 1'b1}, ack); chk({req, " R2 read address ack"}, {31'd0, ack}, 32'd1);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(exp);
      tag_q.push_back(req);
      rd_byte(k != n - 1, b);
      act_q.push_back(b);
    end
    i2c_stop();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic ack;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 pin_oe", {24'd0, pin_oe}, 32'h00);
    chk("R1 pin_out", {24'd0, pin_out}, 32'hFF);
    chk("R1 irq_n", {31'd0, irq_n}, 32'd1);
    chk("R1 sda released", {31'd0, sda_drive_low}, 32'd0);
    reg_read(8'd1, 8'hFF, 1, "R1 output default");
    reg_read(8'd2, 8'h00, 1, "R1 polarity default");
    reg_read(8'd3, 8'hFF, 1, "R1 direction default");

    // R6 input read with and without polarity
    reg_read(8'd0, 8'hA5, 1, "R6 input plain");
    reg_write(8'd2, 8'h0F, "R5 polarity write");
    reg_read(8'd0, 8'hAA, 1, "R6 input inverted");
    reg_read(8'd2, 8'h0F, 2, "R5 repeated polarity read");

    // R2 wrong address ignored
    i2c_start();
    wr_byte({7'h71, 1'b0}, ack); chk("R2 foreign address nack", {31'd0, ack}, 32'd0);
    wr_byte(8'd1, ack);
    wr_byte(8'h00, ack);
    i2c_stop();
    repeat (4) @(negedge clk);
    chk("R2 foreign write no effect", {24'd0, pin_out}, 32'hFF);

    // R3 out-of-range command
    i2c_start();
    wr_byte({DEV, 1'b0}, ack); chk("R3 address ack", {31'd0, ack}, 32'd1);
    wr_byte(8'd4, ack);        chk("R3 command 4 nack", {31'd0, ack}, 32'd0);
    i2c_stop();
    repeat (4) @(negedge clk);

    // R4 output and direction
    reg_write(8'd1, 8'h3C, "R4 output write");
    reg_write(8'd3, 8'hF0, "R4 direction write");
    chk("R4 pin_out", {24'd0, pin_out}, 32'h3C);
    chk("R4 pin_oe", {24'd0, pin_oe}, 32'h0F);
    reg_read(8'd3, 8'hF0, 3, "R5 direction readback");
    reg_read(8'd1, 8'h3C, 1, "R5 output readback");

    // R7 output pin ignored, input pin raises interrupt at third edge
    pin_in = 8'hA4;
    repeat (10) @(negedge clk);
    chk("R7 output-pin change ignored", {31'd0, irq_n}, 32'd1);
    pin_in = 8'h24;
    repeat (2) @(negedge clk);
    chk("R7 irq not before third edge", {31'd0, irq_n}, 32'd1);
    @(negedge clk);
    chk("R7 irq at third edge", {31'd0, irq_n}, 32'd0);

    // R8 clear by reading register 0, and by pins returning
    reg_read(8'd0, 8'h2B, 1, "R8 capture read");
    chk("R8 irq released after read", {31'd0, irq_n}, 32'd1);
    pin_in = 8'hA4;
    repeat (5) @(negedge clk);
    chk("R8 irq on new change", {31'd0, irq_n}, 32'd0);
    pin_in = 8'h24;
    repeat (5) @(negedge clk);
    chk("R8 irq released on return", {31'd0, irq_n}, 32'd1);

    // R10 write to register 0 ignored
    reg_write(8'd0, 8'h55, "R10 input write");
    chk("R10 irq unchanged", {31'd0, irq_n}, 32'd1);
    reg_read(8'd0, 8'h2B, 1, "R10 input unchanged");

    // R9 reset pin during a transfer
    i2c_start();
    wr_byte({DEV, 1'b0}, ack);
    wr_byte(8'd1, ack);
    rst_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_pin_n = 1'b1;
    wr_byte(8'h00, ack);
    i2c_stop();
    repeat (4) @(negedge clk);
    chk("R9 pin_out default", {24'd0, pin_out}, 32'hFF);
    chk("R9 pin_oe default", {24'd0, pin_oe}, 32'h00);
    chk("R9 irq_n", {31'd0, irq_n}, 32'd1);
    reg_read(8'd2, 8'h00, 1, "R9 polarity default");

    repeat (8) @(negedge clk);
    chk("scoreboard drained", exp_q.size() + act_q.size(), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule